// File: doc/BRIEF.md
# Trigger-Positioned Capture Buffer Controller

This block runs the circular sample store of a logic-analysis acquisition. After an arm pulse it writes one sample per clock into a power-of-two memory, but only on cycles where store qualification allows it. Qualification comes from a default store flag, which sequencer actions can turn on or off while a run is in progress. The active sequence level can override that flag with its own store or don't-store choice. The write pointer wraps, so recent pre-trigger history is always kept.

When the trigger event arrives, the block places it in the record at the selected position: first sample, middle, last sample, or a programmed offset. The trigger sample is always written. The block then keeps storing qualified samples until the post-trigger part of the record is complete, and stops. It reports where the trigger sample and the oldest valid sample sit in memory and how much pre-trigger history was actually held. Once the acquisition is complete, a read port returns the record in time order, addressed as an offset from the oldest sample.

Top module: `capbuf_ctrl`

## Requirements
- R1: After reset the block is idle: `done` and `busy` are 0, and `trig_idx`, `oldest_idx`, `pre_cnt` and `rd_data` are 0.
- R2: An `arm` pulse restarts an acquisition from any state. From the next cycle `busy`=1 and `done`=0. The write pointer and the history count return to 0. No sample is written and no trigger is taken in the arm cycle.
- R3: On a non-trigger cycle a sample is stored if `lvl_ovr_en`=1 and `lvl_ovr_store`=1, or if `lvl_ovr_en`=0 and the default store flag is 1. Unstored samples do not advance the write pointer or any count.
- R4: The default store flag is 1 after reset. `dflt_on` sets it and `dflt_off` clears it, with `dflt_on` winning when both are high. The change applies from the following cycle.
- R5: The pre-trigger count P is decoded from `pos_sel`: 0 gives P=0, 1 gives P=DEPTH/2, 2 gives P=DEPTH-1, and 3 gives P=`pos_user`.
- R6: A trigger taken during the pre-trigger phase writes that cycle's sample whatever the qualification. `trig_idx` becomes that sample's memory index.
- R7: After the trigger sample, exactly DEPTH-P-1 further qualified samples are written. `done` rises the cycle after the last of them is written, or the cycle after the trigger when P=DEPTH-1.
- R8: If at least P samples were stored before the trigger, `oldest_idx` = (`trig_idx` - P) mod DEPTH and `pre_cnt` = P. Otherwise `oldest_idx` = 0 and `pre_cnt` equals the number of samples stored before the trigger.
- R9: A trigger while idle, in the post-trigger phase, or after `done` has no effect: `trig_idx`, `oldest_idx` and `pre_cnt` keep their values, and `done` stays high until the next arm.
- R10: While `done`=1, `rd_en` with `rd_addr`=k returns on `rd_data` one cycle later the k-th oldest sample of the record, taken from memory index (`oldest_idx`+k) mod DEPTH. At other times `rd_data` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm | input | 1 | Start a new acquisition |
| trig | input | 1 | Trigger event from the sequencer |
| smp_data | input | DATA_W | Sample word for this cycle |
| pos_sel | input | 2 | Trigger position select (start, center, end, user) |
| pos_user | input | AW | User pre-trigger count |
| dflt_on | input | 1 | Turn default storing on |
| dflt_off | input | 1 | Turn default storing off |
| lvl_ovr_en | input | 1 | Current level overrides default storing |
| lvl_ovr_store | input | 1 | Level's store choice when overriding |
| rd_en | input | 1 | Read request |
| rd_addr | input | AW | Chronological offset from oldest sample |
| rd_data | output | DATA_W | Read sample, one cycle after request |
| busy | output | 1 | Acquisition in progress |
| done | output | 1 | Record complete |
| trig_idx | output | AW | Memory index of trigger sample |
| oldest_idx | output | AW | Memory index of oldest valid sample |
| pre_cnt | output | AW | Pre-trigger samples actually held |

## Verification
The capture is run with a long history before a center trigger, so the buffer wraps and the oldest index must be computed modulo the depth. It is also run with a short history before a large user offset, which tells the fill-limited case of the oldest index and history count apart from the normal case. A start-position run with default storing switched off, then overridden on and off by the level, shows whether unqualified samples leak into the pointer or the post-trigger count. An end-position run checks completion on the cycle after the trigger, and stray triggers and reads around completion and a mid-run re-arm check the hold and restart behaviour.

// File: rtl/capbuf_pkg.sv
package capbuf_pkg;
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_PRE  = 2'd1,
      PH_POST = 2'd2,
      PH_DONE = 2'd3
   } phase_t;

   typedef enum logic [1:0] {
      POS_START  = 2'd0,
      POS_CENTER = 2'd1,
      POS_END    = 2'd2,
      POS_USER   = 2'd3
   } pos_t;
endpackage

// File: rtl/capbuf_qual.sv
module capbuf_qual (
   input  logic clk,
   input  logic rst_n,
   input  logic dflt_on,
   input  logic dflt_off,
   input  logic lvl_ovr_en,
   input  logic lvl_ovr_store,
   output logic store
);
   logic dflt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)        dflt_q <= 1'b1;
      else if (dflt_on)  dflt_q <= 1'b1;
      else if (dflt_off) dflt_q <= 1'b0;
   end

   assign store = lvl_ovr_en ? lvl_ovr_store : dflt_q;
endmodule

// File: rtl/capbuf_pos.sv
module capbuf_pos
   import capbuf_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter int AW    = $clog2(DEPTH)
) (
   input  logic [1:0]    pos_sel,
   input  logic [AW-1:0] pos_user,
   output logic [AW-1:0] pre
);
   localparam logic [AW-1:0] MID  = AW'(DEPTH / 2);
   localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

   always_comb begin
      unique case (pos_t'(pos_sel))
         POS_START:  pre = '0;
         POS_CENTER: pre = MID;
         POS_END:    pre = LAST;
         default:    pre = pos_user;
      endcase
   end
endmodule

// File: rtl/capbuf_mem.sv
module capbuf_mem #(
   parameter int DEPTH  = 16,
   parameter int DATA_W = 8,
   parameter int AW     = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [AW-1:0]     wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   input  logic [AW-1:0]     rd_addr,
   output logic [DATA_W-1:0] rd_data
);
   logic [DATA_W-1:0] store_q [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) store_q[wr_addr] <= wr_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     rd_data <= '0;
      else if (rd_en) rd_data <= store_q[rd_addr];
   end
endmodule

// File: rtl/capbuf_ctrl.sv
module capbuf_ctrl
   import capbuf_pkg::*;
#(
   parameter int DEPTH  = 16,
   parameter int DATA_W = 8,
   parameter int AW     = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              arm,
   input  logic              trig,
   input  logic [DATA_W-1:0] smp_data,
   input  logic [1:0]        pos_sel,
   input  logic [AW-1:0]     pos_user,
   input  logic              dflt_on,
   input  logic              dflt_off,
   input  logic              lvl_ovr_en,
   input  logic              lvl_ovr_store,
   input  logic              rd_en,
   input  logic [AW-1:0]     rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              busy,
   output logic              done,
   output logic [AW-1:0]     trig_idx,
   output logic [AW-1:0]     oldest_idx,
   output logic [AW-1:0]     pre_cnt
);
   localparam logic [AW-1:0] LAST  = AW'(DEPTH - 1);
   localparam logic [AW:0]   FULL  = (AW+1)'(DEPTH);

   generate
      if (DEPTH < 4 || DEPTH != (1 << AW)) begin : g_bad_depth
         $error("capbuf_ctrl: DEPTH must be a power of two of at least 4");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("capbuf_ctrl: DATA_W must be positive");
      end
   endgenerate

   phase_t          ph_q;
   logic [AW-1:0]   wp_q;
   logic [AW:0]     fill_q;
   logic [AW-1:0]   rem_q;
   logic            store;
   logic [AW-1:0]   pre;
   logic [AW-1:0]   post_m1;
   logic            hist_ok;
   logic            take_trig;
   logic            wr_en;
   logic            rd_go;
   logic [AW-1:0]   rd_ptr;

   capbuf_qual u_qual (
      .clk           (clk),
      .rst_n         (rst_n),
      .dflt_on       (dflt_on),
      .dflt_off      (dflt_off),
      .lvl_ovr_en    (lvl_ovr_en),
      .lvl_ovr_store (lvl_ovr_store),
      .store         (store)
   );

   capbuf_pos #(.DEPTH(DEPTH), .AW(AW)) u_pos (
      .pos_sel  (pos_sel),
      .pos_user (pos_user),
      .pre      (pre)
   );

   assign post_m1   = LAST - pre;
   assign hist_ok   = fill_q >= {1'b0, pre};
   assign take_trig = !arm && (ph_q == PH_PRE) && trig;
   assign wr_en     = !arm && (((ph_q == PH_PRE) && (trig || store)) ||
                               ((ph_q == PH_POST) && store));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph_q       <= PH_IDLE;
         wp_q       <= '0;
         fill_q     <= '0;
         rem_q      <= '0;
         trig_idx   <= '0;
         oldest_idx <= '0;
         pre_cnt    <= '0;
      end else if (arm) begin
         ph_q   <= PH_PRE;
         wp_q   <= '0;
         fill_q <= '0;
      end else begin
         unique case (ph_q)
            PH_PRE: begin
               if (take_trig) begin
                  trig_idx   <= wp_q;
                  oldest_idx <= hist_ok ? (wp_q - pre) : '0;
                  pre_cnt    <= hist_ok ? pre : fill_q[AW-1:0];
                  wp_q       <= wp_q + 1'b1;
                  rem_q      <= post_m1;
                  ph_q       <= (post_m1 == '0) ? PH_DONE : PH_POST;
               end else if (store) begin
                  wp_q <= wp_q + 1'b1;
                  if (fill_q != FULL) fill_q <= fill_q + 1'b1;
               end
            end
            PH_POST: begin
               if (store) begin
                  wp_q  <= wp_q + 1'b1;
                  rem_q <= rem_q - 1'b1;
                  if (rem_q == AW'(1)) ph_q <= PH_DONE;
               end
            end
            default: ;
         endcase
      end
   end

   assign busy   = (ph_q == PH_PRE) || (ph_q == PH_POST);
   assign done   = (ph_q == PH_DONE);
   assign rd_go  = rd_en && done;
   assign rd_ptr = oldest_idx + rd_addr;

   capbuf_mem #(.DEPTH(DEPTH), .DATA_W(DATA_W), .AW(AW)) u_mem (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wp_q),
      .wr_data (smp_data),
      .rd_en   (rd_go),
      .rd_addr (rd_ptr),
      .rd_data (rd_data)
   );
endmodule

// File: rtl/capbuf_chk.sv
module capbuf_chk #(
   parameter int DATA_W = 8,
   parameter int AW     = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              arm,
   input logic              trig,
   input logic              rd_en,
   input logic              busy,
   input logic              done,
   input logic [AW-1:0]     trig_idx,
   input logic [AW-1:0]     oldest_idx,
   input logic [DATA_W-1:0] rd_data
);
   // R1: the two run flags are never high together
   assert_flags_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy && done));

   // R2: arm always leads into an active capture
   assert_arm_starts_R2: assert property (@(posedge clk) disable iff (!rst_n)
      arm |=> (busy && !done));

   // R9: a finished record stays finished until re-armed
   assert_done_sticks_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !arm) |=> done);

   // R9: a trigger outside the capture phase leaves the indices alone
   assert_trig_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (trig && !arm && !busy) |=> ($stable(trig_idx) && $stable(oldest_idx)));

   // R10: read data moves only on a read while done
   assert_rd_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_en && done) |=> $stable(rd_data));
endmodule

bind capbuf_ctrl capbuf_chk #(.DATA_W(DATA_W), .AW(AW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .arm        (arm),
   .trig       (trig),
   .rd_en      (rd_en),
   .busy       (busy),
   .done       (done),
   .trig_idx   (trig_idx),
   .oldest_idx (oldest_idx),
   .rd_data    (rd_data)
);

// File: tb/sim_capbuf_ctrl.sv
module sim_capbuf_ctrl;
   localparam int D  = 16;
   localparam int DW = 8;
   localparam int AW = 4;

   logic clk = 0;
   logic rst_n = 0;
   logic arm = 0, trig = 0;
   logic [DW-1:0] smp_data = 0;
   logic [1:0] pos_sel = 0;
   logic [AW-1:0] pos_user = 0;
   logic dflt_on = 0, dflt_off = 0, lvl_ovr_en = 0, lvl_ovr_store = 0;
   logic rd_en = 0;
   logic [AW-1:0] rd_addr = 0;
   logic [DW-1:0] rd_data;
   logic busy, done;
   logic [AW-1:0] trig_idx, oldest_idx, pre_cnt;

   always #4 clk = ~clk;

   capbuf_ctrl #(.DEPTH(D), .DATA_W(DW)) u0 (
      .clk(clk), .rst_n(rst_n), .arm(arm), .trig(trig), .smp_data(smp_data),
      .pos_sel(pos_sel), .pos_user(pos_user), .dflt_on(dflt_on), .dflt_off(dflt_off),
      .lvl_ovr_en(lvl_ovr_en), .lvl_ovr_store(lvl_ovr_store), .rd_en(rd_en),
      .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy), .done(done),
      .trig_idx(trig_idx), .oldest_idx(oldest_idx), .pre_cnt(pre_cnt));

   int n_tests = 0, n_fail = 0;
   int cyc = 0;
   bit finished = 0;

   // behavioural reference: phase 0 idle, 1 pre, 2 post, 3 done
   int m_st, m_fill, m_wp, m_rem, m_tidx, m_old, m_pcnt;
   bit m_dflt, m_rd_known;
   int m_rd;
   int q[$];

   function automatic int pos_of(int sel, int usr);
      case (sel)
         0: return 0;
         1: return D / 2;
         2: return D - 1;
         default: return usr;
      endcase
   endfunction

   always @(posedge clk) begin
      bit qual;
      int p, have;
      if (!rst_n) begin
         m_st = 0; m_fill = 0; m_wp = 0; m_rem = 0;
         m_tidx = 0; m_old = 0; m_pcnt = 0; m_dflt = 1;
         m_rd = 0; m_rd_known = 1; q.delete();
      end else begin
         if (rd_en && m_st == 3) begin
            if (int'(rd_addr) < q.size()) begin m_rd = q[rd_addr]; m_rd_known = 1; end
            else m_rd_known = 0;
         end
         qual = lvl_ovr_en ? lvl_ovr_store : m_dflt;
         if (dflt_on) m_dflt = 1; else if (dflt_off) m_dflt = 0;
         if (arm) begin
            m_st = 1; m_fill = 0; m_wp = 0; q.delete();
         end else if (m_st == 1) begin
            if (trig) begin
               p = pos_of(pos_sel, pos_user);
               have = (m_fill < p) ? m_fill : p;
               while (q.size() > have) void'(q.pop_front());
               q.push_back(smp_data);
               m_tidx = m_wp;
               m_old = (m_fill >= p) ? ((m_wp - p) & (D - 1)) : 0;
               m_pcnt = have;
               m_wp = (m_wp + 1) % D;
               m_rem = D - p - 1;
               m_st = (m_rem == 0) ? 3 : 2;
            end else if (qual) begin
               q.push_back(smp_data);
               if (q.size() > D) void'(q.pop_front());
               m_wp = (m_wp + 1) % D;
               if (m_fill < D) m_fill++;
            end
         end else if (m_st == 2 && qual) begin
            q.push_back(smp_data);
            m_wp = (m_wp + 1) % D;
            m_rem--;
            if (m_rem == 0) m_st = 3;
         end
      end
   end

   task automatic chk(string tag, int act, int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
      end
   endtask

   task automatic compare();
      chk("R7 done", done, m_st == 3);
      chk("R2 busy", busy, m_st == 1 || m_st == 2);
      chk("R6 trig_idx", trig_idx, m_tidx);
      chk("R8 oldest_idx", oldest_idx, m_old);
      chk("R8 pre_cnt", pre_cnt, m_pcnt);
      if (m_rd_known) chk("R10 rd_data", rd_data, m_rd);
   endtask

   int seq = 0;
   task automatic tick();
      @(posedge clk);
      #2;
      cyc++;
      compare();
      seq++;
      smp_data = DW'(seq * 37 + 5);
   endtask

   task automatic clear_ctl();
      arm = 0; trig = 0; dflt_on = 0; dflt_off = 0; rd_en = 0;
   endtask

   task automatic run(int n);
      for (int i = 0; i < n; i++) tick();
   endtask

   task automatic finish_capture();
      for (int i = 0; i < 40 && !done; i++) tick();
   endtask

   task automatic read_all();
      rd_en = 1;
      for (int k = 0; k < D; k++) begin rd_addr = AW'(k); tick(); end
      rd_en = 0;
      tick();
   endtask

   task automatic do_arm();
      arm = 1; tick(); arm = 0;
   endtask

   task automatic fire(int sel, int usr);
      pos_sel = 2'(sel); pos_user = AW'(usr); trig = 1; tick(); trig = 0;
   endtask

   initial begin : watchdog
      #400000;
      if (!finished) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog expired: actual hung expected finish");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      logic [DW-1:0] held;
      logic [AW-1:0] ti;
      run(3);
      rst_n = 1;
      tick();
      // R1 reset state
      chk("R1 done", done, 0);
      chk("R1 busy", busy, 0);
      chk("R1 trig_idx", trig_idx, 0);
      chk("R1 rd_data", rd_data, 0);
      // R9 trigger while idle ignored
      fire(1, 0);
      chk("R9 idle trig", busy, 0);

      // center trigger with wrapped history (R2, R5, R6, R7, R8, R10)
      do_arm();
      chk("R2 busy after arm", busy, 1);
      run(20);
      fire(1, 0);
      chk("R5 center pre_cnt", pre_cnt, D / 2);
      chk("R8 oldest wraps", oldest_idx, (int'(trig_idx) - D / 2) & (D - 1));
      finish_capture();
      chk("R7 center done", done, 1);
      read_all();

      // short history before a large user offset (R5, R8)
      do_arm();
      run(3);
      fire(3, 10);
      chk("R8 short oldest", oldest_idx, 0);
      chk("R8 short pre_cnt", pre_cnt, 3);
      chk("R6 short trig_idx", trig_idx, 3);
      finish_capture();
      read_all();

      // qualification (R3, R4): default off from the arm cycle
      dflt_off = 1; arm = 1; tick(); clear_ctl();
      run(5);
      lvl_ovr_en = 1; lvl_ovr_store = 1; run(2);
      lvl_ovr_store = 0; run(2);
      lvl_ovr_en = 0; dflt_on = 1; tick(); dflt_on = 0;
      run(2);
      fire(0, 0);
      chk("R3 R4 stored count via trig_idx", trig_idx, 4);
      chk("R5 start pre_cnt", pre_cnt, 0);
      chk("R8 start oldest", oldest_idx, 4);
      dflt_on = 1; dflt_off = 1; tick(); clear_ctl();
      lvl_ovr_en = 1; lvl_ovr_store = 0; run(3);
      chk("R3 override holds post", done, 0);
      lvl_ovr_en = 0;
      finish_capture();
      chk("R4 set wins", done, 1);
      read_all();

      // end position (R7) and stray triggers (R9)
      do_arm();
      run(20);
      fire(2, 0);
      chk("R7 end done next cycle", done, 1);
      ti = trig_idx;
      fire(0, 0);
      chk("R9 trig after done", trig_idx, ti);
      chk("R9 done held", done, 1);
      read_all();

      // read during capture has no effect, arm mid-post restarts (R10, R2)
      held = rd_data;
      do_arm();
      run(4);
      fire(0, 0);
      rd_en = 1; rd_addr = 2; run(3); rd_en = 0;
      chk("R10 no read while busy", rd_data, held);
      fire(1, 0);
      chk("R9 trig in post", trig_idx, 4);
      do_arm();
      chk("R2 rearm busy", busy, 1);
      run(10);
      fire(3, 6);
      chk("R5 user pre_cnt", pre_cnt, 6);
      finish_capture();
      read_all();

      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule